// File: doc/BRIEF.md
# Passive LCD Line and Frame Timing Generator

This block drives a passive (non-TFT) monochrome or STN panel. A fixed clock divider, reloaded with a programmable value, sets the pixel period. The block then walks each line through four segments: an active segment that shifts pixel groups onto the parallel data bus under a gated shift clock, a wait, a horizontal sync pulse and a second wait. A vertical sync marks the first line of each frame. Pixel groups, one bus word per shift clock, arrive on a valid/ready stream.

All timing settings are taken into a shadow copy only when a frame starts, so software may write new values at any time. A group that has not arrived when it is needed leaves the bus unchanged and raises a sticky underrun flag, which stays set until the next frame begins. A settings check flags any shift clock that would be faster than one fifth of the system clock.

Top module: `stn_timing_gen`

## Requirements
- R1: While reset is asserted, vsync_o, hsync_o, sclk_o, ld_o, underrun_o, s_ready_o and cfg_err_o are all 0.
- R2: One pixel period lasts pix_div_i+1 clocks. The shift clock period is G pixel periods, where G = 2 << bus_sel_i (2, 4, 8 or 16). Within each group the shift clock is inactive for the first G/2 pixel periods and active for the last G/2.
- R3: Each line is, in pixel periods: an active segment of xmax_i (a nonzero multiple of G), then a wait of hwait_a_i+1, then the horizontal sync pulse of hwidth_i+1, then a wait of hwait_b_i+2. The shift clock is idle outside the active segment.
- R4: A frame holds lines_i lines. vsync is active for the whole of line 0 and inactive on every other line, so it rises on the boundary after the last line of the previous frame.
- R5: Each of vsync_o, hsync_o and sclk_o equals its active level XOR its own polarity bit, where polarity bit 1 means active low.
- R6: s_ready_o is high for exactly one clock, the last clock before each group starts (and the first clock after reset). ld_o takes s_data_i at that clock edge when s_valid_i is high.
- R7: If s_valid_i is low while s_ready_o is high, ld_o keeps its value and underrun_o becomes 1. underrun_o stays 1 until the edge that starts the next frame.
- R8: All settings (divider, bus width, line length, line count, waits, sync width, polarities) take effect only at the edge that starts a frame. Changes in the middle of a frame have no effect on the outputs until then.
- R9: Once running, cfg_err_o is 1 exactly when the active settings give (pix_div+1)*G < 5, that is, a shift clock faster than the system clock divided by five.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_div_i | input | 8 | Pixel period minus one, in clocks |
| bus_sel_i | input | 2 | Group size select, G = 2 << value |
| xmax_i | input | 12 | Active pixels per line |
| lines_i | input | 10 | Lines per frame |
| hwidth_i | input | 8 | Horizontal sync width minus one |
| hwait_a_i | input | 8 | Wait after the active segment, minus one |
| hwait_b_i | input | 8 | Wait after horizontal sync, minus two |
| vpol_i | input | 1 | vsync polarity (1 = active low) |
| hpol_i | input | 1 | hsync polarity (1 = active low) |
| spol_i | input | 1 | Shift clock polarity (1 = active low) |
| s_valid_i | input | 1 | Pixel group available |
| s_data_i | input | LD_W | Pixel group |
| s_ready_o | output | 1 | Group is taken at this edge |
| vsync_o | output | 1 | Frame sync |
| hsync_o | output | 1 | Line sync |
| sclk_o | output | 1 | Gated shift clock |
| ld_o | output | LD_W | Panel data bus |
| underrun_o | output | 1 | Sticky group-missing flag |
| cfg_err_o | output | 1 | Shift clock too fast for the settings |

## Verification
The sync and shift clock outputs are decoded from registers, so they change one clock after the divider tick that moves the line position. The bench's model therefore advances its pixel position only on the clock where its own divider count reaches the limit. s_ready_o is valid during the clock before a group starts, and the bus word and the underrun flag appear after that one edge. The bench samples every output one nanosecond after each falling edge, before it drives the next stream word. New settings count from the edge where the model's frame wraps, and the shadowed values appear in the next sample.

// File: rtl/stn_timing_pkg.sv
package stn_timing_pkg;

  localparam int DIV_W  = 8;
  localparam int SEL_W  = 2;
  localparam int X_W    = 12;
  localparam int Y_W    = 10;
  localparam int W_W    = 8;
  localparam int LEN_W  = X_W + 1;
  localparam int PROD_W = DIV_W + LEN_W + 1;

  typedef enum logic [2:0] {
    PH_START, PH_ACTIVE, PH_WAIT1, PH_HSYNC, PH_WAIT2
  } phase_t;

  typedef struct packed {
    logic [DIV_W-1:0] pdiv;
    logic [SEL_W-1:0] bus_sel;
    logic [X_W-1:0]   xmax;
    logic [Y_W-1:0]   lines;
    logic [W_W-1:0]   hwidth;
    logic [W_W-1:0]   wait_a;
    logic [W_W-1:0]   wait_b;
    logic             pol_v;
    logic             pol_h;
    logic             pol_s;
  } cfg_t;

  // pixels carried by one shift clock period
  function automatic logic [LEN_W-1:0] group_pix(input logic [SEL_W-1:0] sel);
    group_pix = LEN_W'(2) << sel;
  endfunction

  // length of a line segment in pixel periods
  function automatic logic [LEN_W-1:0] phase_len(input phase_t ph, input cfg_t c);
    case (ph)
      PH_ACTIVE: phase_len = LEN_W'(c.xmax);
      PH_WAIT1:  phase_len = LEN_W'(c.wait_a) + LEN_W'(1);
      PH_HSYNC:  phase_len = LEN_W'(c.hwidth) + LEN_W'(1);
      PH_WAIT2:  phase_len = LEN_W'(c.wait_b) + LEN_W'(2);
      default:   phase_len = LEN_W'(1);
    endcase
  endfunction

  // shift period in clocks below five
  function automatic logic too_fast(input cfg_t c);
    logic [PROD_W-1:0] prod;
    prod = (PROD_W'(c.pdiv) + PROD_W'(1)) * PROD_W'(group_pix(c.bus_sel));
    too_fast = prod < PROD_W'(5);
  endfunction

endpackage

// File: rtl/stn_pix_div.sv
module stn_pix_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!run || cnt == limit)  cnt <= '0;
    else                            cnt <= cnt + W'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> (!tick || limit == '0)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit)); // R2

endmodule

// File: rtl/stn_line_seq.sv
module stn_line_seq
  import stn_timing_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  cfg_t cfg,
  output logic running,
  output logic frame_start,
  output logic load,
  output logic vs_act,
  output logic hs_act,
  output logic sc_act
);

  phase_t         ph, nph;
  logic [X_W-1:0] cnt, ncnt;
  logic [Y_W-1:0] line, nline;
  logic           wrap;
  logic           seg_end;
  logic [LEN_W-1:0] len, mask;

  assign len     = phase_len(ph, cfg);
  assign mask    = group_pix(cfg.bus_sel) - LEN_W'(1);
  assign seg_end = tick && ({1'b0, cnt} == len - LEN_W'(1));

  always_comb begin
    nph   = ph;
    ncnt  = cnt;
    nline = line;
    wrap  = 1'b0;
    if (ph == PH_START) begin
      nph   = PH_ACTIVE;
      ncnt  = '0;
      nline = '0;
    end else if (seg_end) begin
      ncnt = '0;
      case (ph)
        PH_ACTIVE: nph = PH_WAIT1;
        PH_WAIT1:  nph = PH_HSYNC;
        PH_HSYNC:  nph = PH_WAIT2;
        default: begin
          nph = PH_ACTIVE;
          if (line == cfg.lines - Y_W'(1)) begin
            nline = '0;
            wrap  = 1'b1;
          end else begin
            nline = line + Y_W'(1);
          end
        end
      endcase
    end else if (tick) begin
      ncnt = cnt + X_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_START;
      cnt  <= '0;
      line <= '0;
    end else begin
      ph   <= nph;
      cnt  <= ncnt;
      line <= nline;
    end
  end

  assign running     = (ph != PH_START);
  assign frame_start = (ph == PH_START) || wrap;
  assign load        = (ph == PH_START) ||
                       (tick && nph == PH_ACTIVE && ((LEN_W'(ncnt) & mask) == '0));
  assign vs_act      = running && (line == '0);
  assign hs_act      = (ph == PH_HSYNC);
  assign sc_act      = (ph == PH_ACTIVE) && cnt[cfg.bus_sel];

  AST_SYNC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_act |-> !sc_act); // R3
  AST_CNT_IN_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ({1'b0, cnt} < len)); // R3
  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (load && running) |-> tick); // R6
  AST_VS_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_act) |-> (ph == PH_ACTIVE && cnt == '0)); // R4

endmodule

// File: rtl/stn_shift_out.sv
module stn_shift_out #(
  parameter int LD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            frame_start,
  input  logic            s_valid,
  input  logic [LD_W-1:0] s_data,
  output logic [LD_W-1:0] ld,
  output logic            underrun
);

  logic take, miss;

  assign take = load && s_valid;
  assign miss = load && !s_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ld <= '0;
    else if (take) ld <= s_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           underrun <= 1'b0;
    else if (miss)        underrun <= 1'b1;
    else if (frame_start) underrun <= 1'b0;
  end

  AST_LD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(ld)); // R6
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> underrun); // R7
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !frame_start) |=> underrun); // R7

endmodule

// File: rtl/stn_timing_gen.sv
module stn_timing_gen
  import stn_timing_pkg::*;
#(
  parameter int LD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  pix_div_i,
  input  logic [SEL_W-1:0]  bus_sel_i,
  input  logic [X_W-1:0]    xmax_i,
  input  logic [Y_W-1:0]    lines_i,
  input  logic [W_W-1:0]    hwidth_i,
  input  logic [W_W-1:0]    hwait_a_i,
  input  logic [W_W-1:0]    hwait_b_i,
  input  logic              vpol_i,
  input  logic              hpol_i,
  input  logic              spol_i,
  input  logic              s_valid_i,
  input  logic [LD_W-1:0]   s_data_i,
  output logic              s_ready_o,
  output logic              vsync_o,
  output logic              hsync_o,
  output logic              sclk_o,
  output logic [LD_W-1:0]   ld_o,
  output logic              underrun_o,
  output logic              cfg_err_o
);

  cfg_t cfg_in, shadow;
  logic tick, running, frame_start, load;
  logic vs_act, hs_act, sc_act;

  always_comb begin
    cfg_in.pdiv    = pix_div_i;
    cfg_in.bus_sel = bus_sel_i;
    cfg_in.xmax    = xmax_i;
    cfg_in.lines   = lines_i;
    cfg_in.hwidth  = hwidth_i;
    cfg_in.wait_a  = hwait_a_i;
    cfg_in.wait_b  = hwait_b_i;
    cfg_in.pol_v   = vpol_i;
    cfg_in.pol_h   = hpol_i;
    cfg_in.pol_s   = spol_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          shadow <= '0;
    else if (frame_start) shadow <= cfg_in;
  end

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(shadow)); // R8

  stn_pix_div #(.W(DIV_W)) u_div (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .run   (running),
    .limit (shadow.pdiv),
    .tick  (tick)
  );

  stn_line_seq u_seq (
    .clk         (clk_i),
    .rst_n       (rst_ni),
    .tick        (tick),
    .cfg         (shadow),
    .running     (running),
    .frame_start (frame_start),
    .load        (load),
    .vs_act      (vs_act),
    .hs_act      (hs_act),
    .sc_act      (sc_act)
  );

  stn_shift_out #(.LD_W(LD_W)) u_shift (
    .clk         (clk_i),
    .rst_n       (rst_ni),
    .load        (load),
    .frame_start (frame_start),
    .s_valid     (s_valid_i),
    .s_data      (s_data_i),
    .ld          (ld_o),
    .underrun    (underrun_o)
  );

  assign s_ready_o = load && rst_ni;
  assign vsync_o   = vs_act ^ shadow.pol_v;
  assign hsync_o   = hs_act ^ shadow.pol_h;
  assign sclk_o    = sc_act ^ shadow.pol_s;
  assign cfg_err_o = running && too_fast(shadow);

  AST_ERR_ONLY_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> running); // R9

endmodule

// File: tb/stn_timing_gen_bench.sv
module stn_timing_gen_bench;

  localparam int LD_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  c_pdiv = '0;
  logic [1:0]  c_sel = '0;
  logic [11:0] c_xmax = 12'd8;
  logic [9:0]  c_lines = 10'd3;
  logic [7:0]  c_hwid = '0, c_wa = '0, c_wb = '0;
  logic        c_pv = 1'b0, c_ph = 1'b0, c_ps = 1'b0;
  logic        s_valid = 1'b0;
  logic [LD_W-1:0] s_data = '0;

  logic s_ready, vsync, hsync, sclk, underrun, cfg_err;
  logic [LD_W-1:0] ld;

  stn_timing_gen #(.LD_W(LD_W)) u_stn_timing_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .pix_div_i(c_pdiv), .bus_sel_i(c_sel), .xmax_i(c_xmax), .lines_i(c_lines),
    .hwidth_i(c_hwid), .hwait_a_i(c_wa), .hwait_b_i(c_wb),
    .vpol_i(c_pv), .hpol_i(c_ph), .spol_i(c_ps),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .vsync_o(vsync), .hsync_o(hsync), .sclk_o(sclk), .ld_o(ld),
    .underrun_o(underrun), .cfg_err_o(cfg_err)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // reference model state
  bit started;
  int y, p, d;
  int m_pdiv, m_bus, m_xmax, m_lines, m_wa, m_hwid, m_wb, m_pv, m_ph, m_ps;
  logic [LD_W-1:0] exp_ld, data_seq;
  bit exp_und, gap_on;

  task automatic chk(input string req, input string nm, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    started = 0; y = 0; p = 0; d = 0;
    m_pdiv = 0; m_bus = 2; m_xmax = 0; m_lines = 0; m_wa = 0; m_hwid = 0; m_wb = 0;
    m_pv = 0; m_ph = 0; m_ps = 0;
    exp_ld = '0; exp_und = 0;
  endtask

  task automatic latch_cfg();
    m_pdiv = c_pdiv; m_bus = 2 << c_sel; m_xmax = c_xmax; m_lines = c_lines;
    m_wa = c_wa; m_hwid = c_hwid; m_wb = c_wb;
    m_pv = c_pv; m_ph = c_ph; m_ps = c_ps;
  endtask

  // one clock of the reference model: compare, drive stream, advance
  task automatic step();
    int linelen, hs0, hs1, np;
    bit av, ah, as_, fetch, err, wrap;
    if (!started) begin
      av = 0; ah = 0; as_ = 0; fetch = 1; err = 0; wrap = 1; np = 0; linelen = 1;
    end else begin
      linelen = m_xmax + m_wa + 1 + m_hwid + 1 + m_wb + 2;
      hs0 = m_xmax + m_wa + 1;
      hs1 = hs0 + m_hwid + 1;
      av  = (y == 0);
      ah  = (p >= hs0) && (p < hs1);
      as_ = (p < m_xmax) && ((p % m_bus) >= m_bus / 2);
      np  = (p + 1 == linelen) ? 0 : p + 1;
      fetch = (d == m_pdiv) && (np < m_xmax) && ((np % m_bus) == 0);
      err = ((m_pdiv + 1) * m_bus) < 5;
      wrap = (d == m_pdiv) && (np == 0) && (y + 1 == m_lines);
    end
    chk("R4 R5", "vsync", vsync, longint'(av ^ m_pv[0]));
    chk("R3 R5 R8", "hsync", hsync, longint'(ah ^ m_ph[0]));
    chk("R2 R5", "sclk", sclk, longint'(as_ ^ m_ps[0]));
    chk("R6 R8", "s_ready", s_ready, longint'(fetch));
    chk("R6", "ld", ld, longint'(exp_ld));
    chk("R7", "underrun", underrun, longint'(exp_und));
    chk("R9", "cfg_err", cfg_err, longint'(err));
    s_valid = !gap_on;
    s_data  = data_seq;
    if (wrap) exp_und = 0;
    if (fetch) begin
      if (s_valid) begin
        exp_ld = data_seq;
        data_seq = data_seq + 16'h0137;
      end else begin
        exp_und = 1;
      end
    end
    if (!started) begin
      started = 1; y = 0; p = 0; d = 0;
      latch_cfg();
    end else if (d == m_pdiv) begin
      d = 0;
      p = np;
      if (np == 0) y = (y + 1 == m_lines) ? 0 : y + 1;
      if (wrap) latch_cfg();
    end else begin
      d = d + 1;
    end
  endtask

  task automatic run(input int n, input bit gap);
    gap_on = gap;
    repeat (n) begin
      @(negedge clk); #1;
      step();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    repeat (2) begin
      #1;
      chk("R1", "vsync", vsync, 0);
      chk("R1", "hsync", hsync, 0);
      chk("R1", "sclk", sclk, 0);
      chk("R1", "ld", ld, 0);
      chk("R1", "underrun", underrun, 0);
      chk("R1", "s_ready", s_ready, 0);
      chk("R1", "cfg_err", cfg_err, 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    #1;
    step();
  endtask

  initial begin
    data_seq = 16'h1A05;
    gap_on = 0;
    model_clear();
    // S1: bus 2, two clocks per pixel
    c_pdiv = 8'd1; c_sel = 2'd0; c_xmax = 12'd8; c_lines = 10'd3;
    c_hwid = 8'd1; c_wa = 8'd0; c_wb = 8'd0; c_pv = 0; c_ph = 0; c_ps = 0;
    do_reset();
    run(150, 0);
    // S2 written mid-frame (R8), inverted polarities (R5), too fast (R9)
    c_pdiv = 8'd0; c_sel = 2'd1; c_xmax = 12'd12; c_lines = 10'd2;
    c_hwid = 8'd2; c_wa = 8'd3; c_wb = 8'd1; c_pv = 1; c_ph = 1; c_ps = 1;
    run(250, 0);
    // S3: bus 8, three clocks per pixel, then a stall for R7
    c_pdiv = 8'd2; c_sel = 2'd2; c_xmax = 12'd16; c_lines = 10'd4;
    c_hwid = 8'd3; c_wa = 8'd2; c_wb = 8'd1; c_pv = 1; c_ph = 0; c_ps = 0;
    run(120, 0);
    run(60, 1);
    run(500, 0);
    // S4: reset again (R1), minimal waits
    c_pdiv = 8'd0; c_sel = 2'd0; c_xmax = 12'd6; c_lines = 10'd2;
    c_hwid = 8'd0; c_wa = 8'd0; c_wb = 8'd0; c_pv = 0; c_ph = 1; c_ps = 1;
    do_reset();
    run(200, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule